// File: doc/BRIEF.md
# CAN Transceiver Mode and Transmit Guard

This block is the digital control core of a high-speed CAN transceiver. It works on sampled logic levels and runs from a fixed reference clock, and it counts every time constant in clock cycles. A standby-select pin picks one of two operating modes. In normal mode the block passes the transmit-data pin to the bus driver and returns the bus comparator's decision on the receive pin. In standby mode the driver and the normal receiver are switched off, the split common-mode output is left floating, and the receive pin shows only the indication from a separate wake-detection block.

The driver is protected in two ways. First, a transmit level held dominant for too long is cut off, and it stays cut off until the transmit pin goes recessive again. Second, a thermal fault flag disables the driver until the flag has cleared and the transmit pin is recessive. When the block leaves standby, it enables the receiver and the split output at once. The transmitter only follows after a settling delay.

Top module: `cantx_ctrl`

## Requirements
- R1: During and after reset, with standby requested, drv_en_o, drv_dom_o, rx_sel_o and split_en_o are 0 and rxd_o is 1.
- R2: In normal mode with no fault, drv_dom_o is the inverse of txd_pin_i (txd 0 = dominant, drv_dom_o 1 = drive dominant). It appears 3 clock edges after the pin changes, behind a two-flop synchronizer and one decision register.
- R3: In normal mode, rxd_o is the inverse of bus_dom_i (bus_dom_i 1 = dominant, rxd_o 0), one edge later. wake_i has no effect on rxd_o in normal mode.
- R4: If txd stays dominant for TIMEOUT_CYC consecutive synchronized cycles in normal mode, drv_dom_o has been 1 for exactly TIMEOUT_CYC cycles. It then returns to 0 and drv_en_o drops.
- R5: After a timeout, the driver stays disabled while txd stays low. Once txd is seen high, drv_en_o returns 4 edges after the pin rises.
- R6: After stby_pin_i falls, rx_sel_o and split_en_o rise after 4 edges. drv_en_o rises only after 4+SETTLE_CYC edges.
- R7: A high therm_fault_i drops drv_en_o 2 edges later. The driver is re-enabled only once the flag is low and the synchronized txd is high.
- R8: After stby_pin_i rises, rx_sel_o, split_en_o and drv_en_o fall 4 edges later. In standby, rxd_o is the inverse of wake_i and bus_dom_i has no effect.
- R9: drv_dom_o is never 1 while drv_en_o is 0, and drv_en_o is never 1 while split_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_pin_i | input | 1 | Mode select, 1 = standby, 0 = normal (asynchronous) |
| txd_pin_i | input | 1 | Transmit data, 0 = dominant (asynchronous) |
| therm_fault_i | input | 1 | Thermal fault flag, synchronous to clk |
| bus_dom_i | input | 1 | Bus comparator output, 1 = dominant, synchronous |
| wake_i | input | 1 | Wake indication from the standby detector, synchronous |
| drv_en_o | output | 1 | Bus driver enable |
| drv_dom_o | output | 1 | Driver level, 1 = dominant |
| rx_sel_o | output | 1 | 1 = normal receiver path, 0 = low-power path |
| split_en_o | output | 1 | Split common-mode output enable |
| rxd_o | output | 1 | Receive data pin, 0 = dominant or wake |

## Verification
The dominant timeout and a thermal fault can latch in the same clock cycle, and each one releases under different conditions. The bench holds txd low until one cycle before the timeout is due, then raises the thermal flag so that both latches set on the same edge. It then releases txd while the flag is still high and checks that the driver stays off. Finally it clears the flag and checks that the driver returns exactly two edges later.

// File: rtl/cantx_pkg.sv
package cantx_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_SETTLE  = 2'd1,
    MODE_NORMAL  = 2'd2
  } cantx_mode_e;
endpackage

// File: rtl/cantx_sync.sv
module cantx_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cantx_mode_ctrl.sv
module cantx_mode_ctrl
  import cantx_pkg::*;
#(
  parameter int SETTLE_CYC = 47
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stby_s_i,
  output cantx_mode_e mode_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  cantx_mode_e mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STANDBY;
      cnt_q  <= '0;
    end else begin
      case (mode_q)
        MODE_STANDBY: begin
          cnt_q <= '0;
          if (!stby_s_i) mode_q <= MODE_SETTLE;
        end
        MODE_SETTLE: begin
          if (stby_s_i) begin
            mode_q <= MODE_STANDBY;
            cnt_q  <= '0;
          end else if (cnt_q == LAST) begin
            mode_q <= MODE_NORMAL;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q <= '0;
          if (stby_s_i) mode_q <= MODE_STANDBY;
        end
      endcase
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cantx_dom_guard.sv
module cantx_dom_guard #(
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic txd_s_i,
  input  logic therm_i,
  output logic block_o
);
  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic tmo_q;
  logic hot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (txd_s_i) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q <= '0;
    end else if (!tmo_q) begin
      if (cnt_q == LAST) tmo_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      hot_q <= 1'b0;
    else if (therm_i)             hot_q <= 1'b1;
    else if (txd_s_i)             hot_q <= 1'b0;
  end

  assign block_o = tmo_q | hot_q;
endmodule

// File: rtl/cantx_ctrl.sv
module cantx_ctrl
  import cantx_pkg::*;
#(
  parameter int SETTLE_CYC  = 47,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_pin_i,
  input  logic txd_pin_i,
  input  logic therm_fault_i,
  input  logic bus_dom_i,
  input  logic wake_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic rx_sel_o,
  output logic split_en_o,
  output logic rxd_o
);
  logic stby_s, txd_s, block;
  cantx_mode_e mode;

  cantx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync_stby (
    .clk(clk), .rst(rst), .d_i(stby_pin_i), .q_o(stby_s));
  cantx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync_txd (
    .clk(clk), .rst(rst), .d_i(txd_pin_i), .q_o(txd_s));

  cantx_mode_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_mode (
    .clk(clk), .rst(rst), .stby_s_i(stby_s), .mode_o(mode));

  cantx_dom_guard #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_guard (
    .clk(clk), .rst(rst), .active_i(mode == MODE_NORMAL),
    .txd_s_i(txd_s), .therm_i(therm_fault_i), .block_o(block));

  logic norm_sel, tx_ok;
  assign norm_sel = (mode != MODE_STANDBY);
  assign tx_ok    = (mode == MODE_NORMAL) && !block;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_o   <= 1'b0;
      drv_dom_o  <= 1'b0;
      rx_sel_o   <= 1'b0;
      split_en_o <= 1'b0;
      rxd_o      <= 1'b1;
    end else begin
      drv_en_o   <= tx_ok;
      drv_dom_o  <= tx_ok && !txd_s;
      rx_sel_o   <= norm_sel;
      split_en_o <= norm_sel;
      rxd_o      <= norm_sel ? !bus_dom_i : !wake_i;
    end
  end
endmodule

// File: rtl/cantx_ctrl_chk.sv
module cantx_ctrl_chk #(
  parameter int TIMEOUT_CYC = 2000
) (
  input logic clk,
  input logic rst,
  input logic therm_fault_i,
  input logic drv_en_o,
  input logic drv_dom_o,
  input logic rx_sel_o,
  input logic split_en_o
);
  localparam int RW = $clog2(TIMEOUT_CYC + 2) + 1;
  logic [RW-1:0] dom_run;

  always_ff @(posedge clk) begin
    if (rst)              dom_run <= '0;
    else if (!drv_dom_o)  dom_run <= '0;
    else if (dom_run <= RW'(TIMEOUT_CYC)) dom_run <= dom_run + 1'b1;
  end

  a_r9_dom_needs_en: assert property (@(posedge clk) disable iff (rst)
    drv_dom_o |-> drv_en_o);
  a_r9_en_needs_split: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> split_en_o);
  a_r8_standby_no_drive: assert property (@(posedge clk) disable iff (rst)
    !rx_sel_o |-> !drv_en_o);
  a_r7_therm_cuts: assert property (@(posedge clk) disable iff (rst)
    therm_fault_i |=> ##1 !drv_en_o);
  a_r4_dom_bounded: assert property (@(posedge clk) disable iff (rst)
    dom_run <= RW'(TIMEOUT_CYC));
endmodule

bind cantx_ctrl cantx_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst(rst), .therm_fault_i(therm_fault_i),
  .drv_en_o(drv_en_o), .drv_dom_o(drv_dom_o),
  .rx_sel_o(rx_sel_o), .split_en_o(split_en_o));

// File: tb/cantx_ctrl_tb.sv
module cantx_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby = 1'b1, txd = 1'b1, therm = 1'b0, busd = 1'b0, wake = 1'b0;
  logic drv_en, drv_dom, rx_sel, split_en, rxd;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cantx_ctrl #(.SETTLE_CYC(S), .TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst(rst), .stby_pin_i(stby), .txd_pin_i(txd),
    .therm_fault_i(therm), .bus_dom_i(busd), .wake_i(wake),
    .drv_en_o(drv_en), .drv_dom_o(drv_dom), .rx_sel_o(rx_sel),
    .split_en_o(split_en), .rxd_o(rxd));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    step(2);
    check("R1 drv_en", drv_en, 1'b0);
    check("R1 drv_dom", drv_dom, 1'b0);
    check("R1 rx_sel", rx_sel, 1'b0);
    check("R1 split", split_en, 1'b0);
    check("R1 rxd", rxd, 1'b1);
    rst = 1'b0;
    step(3);
    check("R1 drv_en after", drv_en, 1'b0);
    check("R1 rxd after", rxd, 1'b1);
  endtask

  task automatic t_settle();
    stby = 1'b0;
    step(3);
    check("R6 rx_sel early", rx_sel, 1'b0);
    step(1);
    check("R6 rx_sel", rx_sel, 1'b1);
    check("R6 split", split_en, 1'b1);
    check("R6 drv_en in settle", drv_en, 1'b0);
    step(S - 1);
    check("R6 drv_en before delay", drv_en, 1'b0);
    step(1);
    check("R6 drv_en after delay", drv_en, 1'b1);
  endtask

  task automatic t_normal();
    txd = 1'b0;
    step(2);
    check("R2 dom latency", drv_dom, 1'b0);
    step(1);
    check("R2 dominant", drv_dom, 1'b1);
    txd = 1'b1;
    step(3);
    check("R2 recessive", drv_dom, 1'b0);
    busd = 1'b1;
    step(1);
    check("R3 rxd dominant", rxd, 1'b0);
    busd = 1'b0; wake = 1'b1;
    step(1);
    check("R3 rxd recessive, wake ignored", rxd, 1'b1);
    wake = 1'b0;
  endtask

  task automatic t_timeout();
    txd = 1'b0;
    step(2 + T);
    check("R4 still dominant", drv_dom, 1'b1);
    step(1);
    check("R4 forced recessive", drv_dom, 1'b0);
    check("R4 driver off", drv_en, 1'b0);
    step(10);
    check("R5 held off", drv_en, 1'b0);
    txd = 1'b1;
    step(3);
    check("R5 not yet", drv_en, 1'b0);
    step(1);
    check("R5 released", drv_en, 1'b1);
  endtask

  task automatic t_thermal();
    therm = 1'b1;
    step(1);
    check("R7 one edge", drv_en, 1'b1);
    step(1);
    check("R7 cut", drv_en, 1'b0);
    therm = 1'b0;
    step(2);
    check("R7 release txd high", drv_en, 1'b1);
    txd = 1'b0;
    step(3);
    therm = 1'b1;
    step(3);
    therm = 1'b0;
    step(3);
    check("R7 held while txd low", drv_en, 1'b0);
    txd = 1'b1;
    step(4);
    check("R7 release on recessive", drv_en, 1'b1);
  endtask

  task automatic t_coincide();
    txd = 1'b0;
    step(1 + T);
    therm = 1'b1;
    step(2);
    check("R4 coincide driver off", drv_en, 1'b0);
    check("R4 coincide dom off", drv_dom, 1'b0);
    txd = 1'b1;
    step(6);
    check("R7 fault still holds", drv_en, 1'b0);
    therm = 1'b0;
    step(1);
    check("R7 one edge after clear", drv_en, 1'b0);
    step(1);
    check("R7 released after clear", drv_en, 1'b1);
  endtask

  task automatic t_standby();
    stby = 1'b1;
    step(3);
    check("R8 rx_sel latency", rx_sel, 1'b1);
    step(1);
    check("R8 rx_sel off", rx_sel, 1'b0);
    check("R8 split off", split_en, 1'b0);
    check("R8 drv off", drv_en, 1'b0);
    txd = 1'b0; busd = 1'b1;
    step(4);
    check("R8 bus ignored", rxd, 1'b1);
    check("R8 no drive", drv_dom, 1'b0);
    wake = 1'b1;
    step(1);
    check("R8 wake shown", rxd, 1'b0);
    wake = 1'b0;
    step(1);
    check("R8 wake released", rxd, 1'b1);
    txd = 1'b1; busd = 1'b0;
  endtask

  initial begin
    t_reset();
    t_settle();
    t_normal();
    t_timeout();
    t_thermal();
    t_coincide();
    t_standby();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule